// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block joins two data buses, called side A and side B, through a 36-bit bidirectional path that is split into two independent 18-bit halves. Each half carries an A-to-B path and a B-to-A path. Each path has one storage element. At run time that element either passes its input through, keeps its value, or loads its input on a rising edge of the path's own clock. The A-to-B and B-to-A paths have output enables of opposite polarity.

Everything runs on one fast system clock. The path control inputs (latch enable, path clock and output enable) are sampled as ordinary synchronous signals. A rising edge of a path clock is found by comparing its sampled value with the value from the previous cycle. Three-state outputs are modelled as a data bus plus a per-bit drive-enable bus. The storage contents stay visible on the data bus whether or not the path drives. Bus hold on each input side is modelled by a keeper. A bit whose source has stopped driving reads as the last level that was driven onto it.

All outputs are registered, so they appear one system-clock cycle after the inputs that cause them.

Top module: `bus_xcvr36`

## Requirements
- R1: While a path's latch enable is 1, its data output in cycle n+1 equals the path's effective input in cycle n (transparent mode).
- R2: While latch enable is 0 and the sampled path clock does not go from 0 to 1, the path's stored value and data output do not change, whatever the data input does.
- R3: With latch enable at 0, a cycle in which the path clock is sampled at 1 after being sampled at 0 in the previous cycle loads that cycle's effective input; the data output shows it one cycle later.
- R4: The A-to-B drive enable of a half is active high: in cycle n+1 all 18 bits of `b_oe_o` for that half equal `ab_oe_i` of cycle n.
- R5: The B-to-A drive enable of a half is active low: in cycle n+1 all 18 bits of `a_oe_o` for that half equal the inverse of `ba_oe_ni` of cycle n.
- R6: Bits [17:0] form half 0 and bits [35:18] form half 1; control bit h of each control port acts only on half h, and the two directions are independent.
- R7: When latch enable falls while the path clock stays at 0, the held value equals the last input loaded while latch enable was 1.
- R8: A data input bit whose drive flag (`a_drv_i`/`b_drv_i`) is 0 is taken as the last value it had while its flag was 1, or 0 if it was never driven since reset.
- R9: While `rst_ni` is 0, all stored values, keepers and sampled path clocks are cleared, and all data outputs and drive enables read 0.
- R10: The data outputs always show the stored value; an output enable changes only the drive-enable bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 36 | Side-A data input |
| a_drv_i | input | 36 | Per-bit flag: side-A input bit is driven |
| b_i | input | 36 | Side-B data input |
| b_drv_i | input | 36 | Per-bit flag: side-B input bit is driven |
| ab_oe_i | input | 2 | A-to-B output enable per half, active high |
| ab_le_i | input | 2 | A-to-B latch enable per half |
| ab_clk_i | input | 2 | A-to-B path clock per half, sampled |
| ba_oe_ni | input | 2 | B-to-A output enable per half, active low |
| ba_le_i | input | 2 | B-to-A latch enable per half |
| ba_clk_i | input | 2 | B-to-A path clock per half, sampled |
| b_o | output | 36 | Side-B data (A-to-B stored value) |
| b_oe_o | output | 36 | Side-B drive enable per bit |
| a_o | output | 36 | Side-A data (B-to-A stored value) |
| a_oe_o | output | 36 | Side-A drive enable per bit |

## Verification
The assertions assume that every control input is already synchronous to the system clock. They also assume that a path clock is a level sampled once per cycle, so a pulse shorter than one system cycle is never expected to cause a load. The stimulus changes all inputs just after the falling system-clock edge. It holds each path-clock level for at least one full cycle, which keeps every 0-to-1 change visible to the edge detector. The drive flags are exercised per bit, so that driven and undriven bits are mixed within one half and the keepers are tested together with the storage modes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int unsigned HALF_W     = 18;
  parameter int unsigned NUM_HALVES = 2;
  localparam int unsigned BUS_W     = HALF_W * NUM_HALVES;
endpackage

// File: rtl/bus_keeper.sv
module bus_keeper #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] drv_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] kept_q;

  assign val_o = (pin_i & drv_i) | (kept_q & ~drv_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kept_q <= '0;
    else         kept_q <= val_o;
  end

  // R8: undriven bits keep their level across cycles
  a_r8_keep_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_i == '0 && $past(drv_i) == '0) |-> $stable(val_o));
endmodule

// File: rtl/path_store.sv
module path_store #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         le_i,
  input  logic         pclk_i,
  input  logic         oe_i,   // already active high
  output logic [W-1:0] q_o,
  output logic [W-1:0] drv_o
);
  logic         pclk_q;
  logic         oe_q;
  logic [W-1:0] st_q;
  logic         rise;
  logic         load;

  assign rise = pclk_i & ~pclk_q;
  assign load = le_i | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_q <= 1'b0;
      oe_q   <= 1'b0;
      st_q   <= '0;
    end else begin
      pclk_q <= pclk_i;
      oe_q   <= oe_i;
      if (load) st_q <= d_i;
    end
  end

  assign q_o   = st_q;
  assign drv_o = {W{oe_q}};

  a_r1_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (q_o == $past(d_i)));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !(pclk_i && !pclk_q)) |=> $stable(q_o));

  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && pclk_i && !pclk_q) |=> (q_o == $past(d_i)));

  // R10: enable does not disturb storage
  a_r10_oe_indep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !pclk_i && oe_i != oe_q) |=> $stable(q_o));
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] a_drv_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] b_drv_i,
  input  logic         ab_oe_i,
  input  logic         ab_le_i,
  input  logic         ab_clk_i,
  input  logic         ba_oe_ni,
  input  logic         ba_le_i,
  input  logic         ba_clk_i,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o
);
  logic [W-1:0] a_eff, b_eff;

  bus_keeper #(.W(W)) u_keep_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(a_i), .drv_i(a_drv_i), .val_o(a_eff)
  );
  bus_keeper #(.W(W)) u_keep_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(b_i), .drv_i(b_drv_i), .val_o(b_eff)
  );

  path_store #(.W(W)) u_ab (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(a_eff), .le_i(ab_le_i),
    .pclk_i(ab_clk_i), .oe_i(ab_oe_i), .q_o(b_o), .drv_o(b_oe_o)
  );
  // B-to-A enable is active low
  path_store #(.W(W)) u_ba (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(b_eff), .le_i(ba_le_i),
    .pclk_i(ba_clk_i), .oe_i(~ba_oe_ni), .q_o(a_o), .drv_o(a_oe_o)
  );
endmodule

// File: rtl/bus_xcvr36.sv
module bus_xcvr36
  import xcvr_pkg::*;
#(
  parameter int unsigned HW = xcvr_pkg::HALF_W,
  parameter int unsigned NH = xcvr_pkg::NUM_HALVES,
  localparam int unsigned BW = HW * NH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] a_drv_i,
  input  logic [BW-1:0] b_i,
  input  logic [BW-1:0] b_drv_i,
  input  logic [NH-1:0] ab_oe_i,
  input  logic [NH-1:0] ab_le_i,
  input  logic [NH-1:0] ab_clk_i,
  input  logic [NH-1:0] ba_oe_ni,
  input  logic [NH-1:0] ba_le_i,
  input  logic [NH-1:0] ba_clk_i,
  output logic [BW-1:0] b_o,
  output logic [BW-1:0] b_oe_o,
  output logic [BW-1:0] a_o,
  output logic [BW-1:0] a_oe_o
);
  for (genvar h = 0; h < NH; h++) begin : g_half
    xcvr_half #(.W(HW)) u_half (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .a_i     (a_i[h*HW +: HW]),
      .a_drv_i (a_drv_i[h*HW +: HW]),
      .b_i     (b_i[h*HW +: HW]),
      .b_drv_i (b_drv_i[h*HW +: HW]),
      .ab_oe_i (ab_oe_i[h]),
      .ab_le_i (ab_le_i[h]),
      .ab_clk_i(ab_clk_i[h]),
      .ba_oe_ni(ba_oe_ni[h]),
      .ba_le_i (ba_le_i[h]),
      .ba_clk_i(ba_clk_i[h]),
      .b_o     (b_o[h*HW +: HW]),
      .b_oe_o  (b_oe_o[h*HW +: HW]),
      .a_o     (a_o[h*HW +: HW]),
      .a_oe_o  (a_oe_o[h*HW +: HW])
    );
  end

  a_r4_ab_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_oe_i == '0) |=> (b_oe_o == '0));

  a_r5_ba_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ba_oe_ni == '1) |=> (a_oe_o == '0));

  a_r5_ba_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ba_oe_ni == '0) |=> (a_oe_o == '1));

  always_comb begin
    if (!rst_ni) begin
      a_r9_reset_clear: assert ((b_o | a_o | b_oe_o | a_oe_o) == '0);
    end
  end
endmodule

// File: tb/bus_xcvr36_tb_top.sv
module bus_xcvr36_tb_top;
  localparam int HW = 18;
  localparam int NH = 2;
  localparam int BW = HW * NH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [BW-1:0] a_in = '0, a_drv = '0, b_in = '0, b_drv = '0;
  logic [NH-1:0] ab_oe = '0, ab_le = '0, ab_clk = '0;
  logic [NH-1:0] ba_oe_n = '1, ba_le = '0, ba_clk = '0;
  logic [BW-1:0] b_o, b_oe, a_o, a_oe;

  bus_xcvr36 dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_in), .a_drv_i(a_drv), .b_i(b_in), .b_drv_i(b_drv),
    .ab_oe_i(ab_oe), .ab_le_i(ab_le), .ab_clk_i(ab_clk),
    .ba_oe_ni(ba_oe_n), .ba_le_i(ba_le), .ba_clk_i(ba_clk),
    .b_o(b_o), .b_oe_o(b_oe), .a_o(a_o), .a_oe_o(a_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R9";

  // reference model, paths 0..1 = A-to-B halves, 2..3 = B-to-A halves
  logic [HW-1:0] m_st [4];
  logic [HW-1:0] m_kp [4];
  logic          m_pc [4];
  logic          m_oe [4];

  function automatic logic [HW-1:0] pin_of(int p);
    return (p < 2) ? a_in[p*HW +: HW] : b_in[(p-2)*HW +: HW];
  endfunction
  function automatic logic [HW-1:0] drv_of(int p);
    return (p < 2) ? a_drv[p*HW +: HW] : b_drv[(p-2)*HW +: HW];
  endfunction
  function automatic logic [HW-1:0] din_of(int p);
    return (pin_of(p) & drv_of(p)) | (m_kp[p] & ~drv_of(p));
  endfunction
  function automatic logic le_of(int p);
    return (p < 2) ? ab_le[p] : ba_le[p-2];
  endfunction
  function automatic logic pc_of(int p);
    return (p < 2) ? ab_clk[p] : ba_clk[p-2];
  endfunction
  function automatic logic oe_of(int p);
    return (p < 2) ? ab_oe[p] : ~ba_oe_n[p-2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) begin
        m_st[p] <= '0; m_kp[p] <= '0; m_pc[p] <= 1'b0; m_oe[p] <= 1'b0;
      end
    end else begin
      for (int p = 0; p < 4; p++) begin
        m_kp[p] <= din_of(p);
        if (le_of(p) || (pc_of(p) && !m_pc[p])) m_st[p] <= din_of(p);
        m_pc[p] <= pc_of(p);
        m_oe[p] <= oe_of(p);
      end
    end
  end

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    logic bad;
    bad = 1'b0;
    for (int p = 0; p < 4; p++) begin
      logic [HW-1:0] ad, ae;
      ad = (p < 2) ? b_o[p*HW +: HW]  : a_o[(p-2)*HW +: HW];
      ae = (p < 2) ? b_oe[p*HW +: HW] : a_oe[(p-2)*HW +: HW];
      if (ad !== m_st[p] || ae !== {HW{m_oe[p]}}) begin
        bad = 1'b1;
        $display("FAIL %s path%0d data=%h/%h exp %h/%h", tag, p, ad, ae,
                 m_st[p], {HW{m_oe[p]}});
      end
    end
    n_chk++;
    if (bad) n_fail++;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expect_val(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] rnd36();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    // R9: enables requested during reset must stay off
    tag = "R9";
    ab_oe = '1; ba_oe_n = '0; ab_le = '1; ba_le = '1;
    a_in = rnd36(); b_in = rnd36(); a_drv = '1; b_drv = '1;
    step(3);
    expect_val("R9", b_o | a_o | b_oe | a_oe, '0);
    rst_n = 1'b1;
    step(1);

    // R1: transparent
    tag = "R1";
    for (int i = 0; i < 10; i++) begin a_in = rnd36(); b_in = rnd36(); step(1); end
    a_in = 36'h123456789; step(1);
    expect_val("R1", b_o, 36'h123456789);

    // R7: hold after latch enable falls with path clock low
    tag = "R7";
    ab_clk = '0; a_in = {18'h3c3c3, 18'h2a5a5}; step(1);
    ab_le = '0; step(1);
    a_in = rnd36(); step(3);
    expect_val("R7", b_o, {18'h3c3c3, 18'h2a5a5});

    // R3: rising path clock loads
    tag = "R3";
    ba_le = '0;
    for (int i = 0; i < 6; i++) begin
      a_in = rnd36(); b_in = rnd36(); ab_clk = '1; ba_clk = '1; step(1);
      a_in = rnd36(); b_in = rnd36(); step(1);
      ab_clk = '0; ba_clk = '0; step(1);
    end
    a_in = 36'h0f0f0f0f0; ab_clk = '1; step(1);
    a_in = rnd36(); step(1);
    expect_val("R3", b_o, 36'h0f0f0f0f0);

    // R2: steady path clock holds at either level
    tag = "R2";
    for (int i = 0; i < 5; i++) begin a_in = rnd36(); b_in = rnd36(); step(1); end
    ab_clk = '0;
    for (int i = 0; i < 5; i++) begin a_in = rnd36(); b_in = rnd36(); step(1); end
    expect_val("R2", b_o, 36'h0f0f0f0f0);

    // R8: bus hold on undriven bits
    tag = "R8";
    ab_le = '1; ba_le = '1;
    for (int i = 0; i < 20; i++) begin
      a_in = rnd36(); b_in = rnd36(); a_drv = rnd36(); b_drv = rnd36(); step(1);
    end
    a_drv = '1; a_in = 36'h5a5a5a5a5; step(1);
    a_drv = '0; a_in = rnd36(); step(3);
    expect_val("R8", b_o, 36'h5a5a5a5a5);
    a_drv = '1; b_drv = '1;

    // R4 / R5: enable polarity
    tag = "R4";
    for (int i = 0; i < 10; i++) begin ab_oe = 2'($urandom()); step(1); end
    ab_oe = 2'b01; step(1);
    expect_val("R4", b_oe, {{HW{1'b0}}, {HW{1'b1}}});
    tag = "R5";
    for (int i = 0; i < 10; i++) begin ba_oe_n = 2'($urandom()); step(1); end
    ba_oe_n = 2'b01; step(1);
    expect_val("R5", a_oe, {{HW{1'b1}}, {HW{1'b0}}});

    // R10: storage visible while not driving
    tag = "R10";
    ab_oe = '0; ba_oe_n = '1;
    b_in = 36'h987654321; step(1);
    expect_val("R10", a_o, 36'h987654321);
    expect_val("R10", a_oe, '0);

    // R6: independent halves, random controls
    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      a_in = rnd36(); b_in = rnd36();
      a_drv = rnd36() | rnd36(); b_drv = rnd36() | rnd36();
      ab_oe = 2'($urandom()); ab_le = 2'($urandom() & $urandom());
      ab_clk = 2'($urandom()); ba_oe_n = 2'($urandom());
      ba_le = 2'($urandom() & $urandom()); ba_clk = 2'($urandom());
      step(1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog %s act=running exp=done", tag);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule